// File: doc/BRIEF.md
# Power-On Reset and Output-Enable Sequencer

This block generates the internal reset and the three-state enables for the output pins of a video front-end. It merges three reset causes: the chip-enable pin driven low, the digital supply-good flag dropping, and the pixel clock stopping. The pin and supply causes assert the internal reset at once, without waiting for a clock edge. The lost-clock cause is found by a watchdog counter that runs on a free-running reference clock. Release of the internal reset is always synchronous to the reference clock.

While the internal reset is active, every output enable is low. The outputs then come back in two groups. The automatic group covers the clock outputs, the real-time control and status lines, the general-purpose switch and the serial data line, and it turns on by itself as soon as reset ends. The sync/reference group covers the horizontal and vertical reference and sync pins. It stays in three-state until a register write sets its two enable bits, and reset clears those bits again. An active-low indicator output lets other circuits follow the reset: it stays low through a window of pixel-clock cycles after the internal reset ends.

Top module: `por_oe_seq`

## Requirements
- R1: While `chip_en_i` is low, `rst_int_n_o` is low and every bit of `oe_auto_o` and `oe_sync_o` is low, with no clock edge needed.
- R2: While `supply_ok_i` is low, `rst_int_n_o` and all output enables are low, with no clock edge needed.
- R3: When the pixel clock stops, `rst_int_n_o` goes low once `LOSS_LIMIT` (64) reference cycles pass without a pixel-clock edge. It is still high 40 reference cycles after the stop. When the pixel clock runs again, the reset releases.
- R4: Once chip-enable and supply are both good and the pixel clock runs, `rst_int_n_o` rises on the 4th reference-clock edge after the last cause clears (two synchronizer stages plus two release stages).
- R5: All `oe_auto_o` bits go high one reference cycle after `rst_int_n_o` rises, and they stay high while it stays high.
- R6: After reset, `oe_sync_o` is 0000 until a write. A reference-clock edge with `cfg_wr_i` high loads `cfg_sync_oe_i`. Bit 0 drives `oe_sync_o[1:0]` (horizontal and vertical reference) and bit 1 drives `oe_sync_o[3:2]` (horizontal and vertical sync).
- R7: Reset clears the sync-group enable bits. A write made while reset is active is ignored. Without a write, the bits hold their value.
- R8: `rst_ind_n_o` is low while the internal reset is active. It rises on the 130th pixel-clock rising edge after `rst_int_n_o` rises: two edges to cross clock domains, then 128 counted cycles.
- R9: If a new reset cause appears during the indicator window, `rst_ind_n_o` is forced low again and the full 130-edge count restarts from the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Line-locked pixel clock, monitored and used for the indicator window |
| ref_clk | input | 1 | Free-running reference clock for the monitor, release and enables |
| chip_en_i | input | 1 | Chip enable; low forces reset |
| supply_ok_i | input | 1 | Supply-good flag; low forces reset |
| cfg_wr_i | input | 1 | Write strobe for the sync-group enable bits (reference domain) |
| cfg_sync_oe_i | input | 2 | Enable bits: bit 0 reference pins, bit 1 sync pins |
| rst_int_n_o | output | 1 | Internal active-low reset |
| rst_ind_n_o | output | 1 | External active-low reset indicator |
| oe_auto_o | output | AUTO_PINS | Per-pin enables of the automatic group |
| oe_sync_o | output | 4 | Per-pin enables: [0] h-ref, [1] v-ref, [2] h-sync, [3] v-sync |

## Verification
On every reference-clock edge, the bound checker confirms four things: the pin and supply causes hold the reset and all enables low; the indicator is low whenever the internal reset is; the automatic group is on throughout a released period; and the sync-group bits change only through a write, which they then match. Three behaviours depend on when they happen, so only the bench scenarios can show them. These are the lost-clock timing window, the exact 130-edge indicator length with its restart when reset returns mid-window, and the clearing of the enable bits across each kind of reset.

// File: rtl/por_oe_pkg.sv
package por_oe_pkg;
  // Sync/reference group layout: one enable bit per pair of pins
  localparam int SYNC_GRP_BITS = 2;
  localparam int PINS_PER_BIT  = 2;
  localparam int SYNC_PINS     = SYNC_GRP_BITS * PINS_PER_BIT;

  typedef struct packed {
    logic pin_low;
    logic supply_low;
    logic clk_lost;
  } rst_cause_t;
endpackage

// File: rtl/por_oe_sync.sv
module por_oe_sync #(
  parameter int W       = 1,
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= {W{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/por_oe_clkmon.sv
module por_oe_clkmon #(
  parameter int LOSS_LIMIT  = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic arst_n,
  input  logic pix_clk,
  output logic clk_lost
);
  localparam int CW = $clog2(LOSS_LIMIT + 1);

  logic          pix_s;
  logic          pix_prev_q;
  logic          pix_edge;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          lost_q, lost_d;

  // Pixel clock sampled as data in the reference domain
  por_oe_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pix_sync (
    .clk    (ref_clk),
    .arst_n (arst_n),
    .d      (pix_clk),
    .q      (pix_s)
  );

  assign pix_edge = pix_s & ~pix_prev_q;

  always_comb begin
    cnt_d  = cnt_q;
    lost_d = lost_q;
    if (pix_edge) begin
      cnt_d  = '0;
      lost_d = 1'b0;
    end else if (cnt_q != CW'(LOSS_LIMIT)) begin
      cnt_d  = cnt_q + 1'b1;
      lost_d = (cnt_q == CW'(LOSS_LIMIT - 1));
    end
  end

  always_ff @(posedge ref_clk or negedge arst_n) begin
    if (!arst_n) begin
      pix_prev_q <= 1'b0;
      cnt_q      <= '0;
      lost_q     <= 1'b0;
    end else begin
      pix_prev_q <= pix_s;
      cnt_q      <= cnt_d;
      lost_q     <= lost_d;
    end
  end

  assign clk_lost = lost_q;
endmodule

// File: rtl/por_oe_rstgen.sv
module por_oe_rstgen
  import por_oe_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REL_STAGES  = 2
) (
  input  logic ref_clk,
  input  logic arst_n,
  input  logic chip_en,
  input  logic supply_ok,
  input  logic clk_lost,
  output logic rst_n
);
  logic [1:0] lvl_s;
  rst_cause_t cause;
  logic       release_ok;

  // Pin and supply levels, cleared asynchronously when either drops
  por_oe_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_lvl_sync (
    .clk    (ref_clk),
    .arst_n (arst_n),
    .d      ({supply_ok, chip_en}),
    .q      (lvl_s)
  );

  always_comb begin
    cause.pin_low    = ~lvl_s[0];
    cause.supply_low = ~lvl_s[1];
    cause.clk_lost   = clk_lost;
    release_ok       = ~(|cause);
  end

  // Immediate assert via arst_n, clean release after REL_STAGES edges
  por_oe_sync #(.W(1), .STAGES(REL_STAGES), .RST_VAL(1'b0)) u_rel_sync (
    .clk    (ref_clk),
    .arst_n (arst_n),
    .d      (release_ok),
    .q      (rst_n)
  );
endmodule

// File: rtl/por_oe_ind.sv
module por_oe_ind #(
  parameter int IND_CYCLES  = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic pix_clk,
  input  logic rst_n,
  output logic ind_n
);
  localparam int CW = $clog2(IND_CYCLES + 1);

  logic          pix_rst_n;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  // Reset bridge into the pixel domain
  por_oe_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_bridge (
    .clk    (pix_clk),
    .arst_n (rst_n),
    .d      (1'b1),
    .q      (pix_rst_n)
  );

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!done_q) begin
      cnt_d  = cnt_q + 1'b1;
      done_d = (cnt_q == CW'(IND_CYCLES - 1));
    end
  end

  always_ff @(posedge pix_clk or negedge pix_rst_n) begin
    if (!pix_rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign ind_n = done_q;
endmodule

// File: rtl/por_oe_seq.sv
module por_oe_seq
  import por_oe_pkg::*;
#(
  parameter int AUTO_PINS   = 7,
  parameter int LOSS_LIMIT  = 64,
  parameter int IND_CYCLES  = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     pix_clk,
  input  logic                     ref_clk,
  input  logic                     chip_en_i,
  input  logic                     supply_ok_i,
  input  logic                     cfg_wr_i,
  input  logic [SYNC_GRP_BITS-1:0] cfg_sync_oe_i,
  output logic                     rst_int_n_o,
  output logic                     rst_ind_n_o,
  output logic [AUTO_PINS-1:0]     oe_auto_o,
  output logic [SYNC_PINS-1:0]     oe_sync_o
);
  logic                     hard_n;
  logic                     clk_lost;
  logic                     rst_n;
  logic [SYNC_GRP_BITS-1:0] grp_q, grp_d;

  assign hard_n = chip_en_i & supply_ok_i;

  por_oe_clkmon #(.LOSS_LIMIT(LOSS_LIMIT), .SYNC_STAGES(SYNC_STAGES)) u_clkmon (
    .ref_clk  (ref_clk),
    .arst_n   (hard_n),
    .pix_clk  (pix_clk),
    .clk_lost (clk_lost)
  );

  por_oe_rstgen #(.SYNC_STAGES(SYNC_STAGES), .REL_STAGES(2)) u_rstgen (
    .ref_clk   (ref_clk),
    .arst_n    (hard_n),
    .chip_en   (chip_en_i),
    .supply_ok (supply_ok_i),
    .clk_lost  (clk_lost),
    .rst_n     (rst_n)
  );

  por_oe_ind #(.IND_CYCLES(IND_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_ind (
    .pix_clk (pix_clk),
    .rst_n   (rst_n),
    .ind_n   (rst_ind_n_o)
  );

  // Automatic group: one enable flop per pin
  for (genvar p = 0; p < AUTO_PINS; p++) begin : g_auto
    logic en_q;
    always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= 1'b1;
    end
    assign oe_auto_o[p] = en_q;
  end

  // Sync/reference group enable register
  always_comb begin
    grp_d = grp_q;
    if (cfg_wr_i) grp_d = cfg_sync_oe_i;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) grp_q <= '0;
    else        grp_q <= grp_d;
  end

  for (genvar g = 0; g < SYNC_GRP_BITS; g++) begin : g_grp
    for (genvar p = 0; p < PINS_PER_BIT; p++) begin : g_pin
      assign oe_sync_o[g*PINS_PER_BIT + p] = grp_q[g];
    end
  end

  assign rst_int_n_o = rst_n;
endmodule

// File: rtl/por_oe_seq_chk.sv
module por_oe_seq_chk #(
  parameter int AUTO_PINS = 7
) (
  input logic                 ref_clk,
  input logic                 chip_en_i,
  input logic                 supply_ok_i,
  input logic                 cfg_wr_i,
  input logic [1:0]           cfg_sync_oe_i,
  input logic                 rst_int_n_o,
  input logic                 rst_ind_n_o,
  input logic [AUTO_PINS-1:0] oe_auto_o,
  input logic [3:0]           oe_sync_o
);
  always @(posedge ref_clk) begin
    if (chip_en_i === 1'b0) begin
      // R1
      pin_rst_chk: assert (rst_int_n_o == 1'b0 && oe_auto_o == '0 && oe_sync_o == '0);
    end
    if (supply_ok_i === 1'b0) begin
      // R2
      supply_rst_chk: assert (rst_int_n_o == 1'b0 && oe_auto_o == '0 && oe_sync_o == '0);
    end
  end

  // R8
  ind_low_chk: assert property (@(posedge ref_clk) disable iff (!chip_en_i)
    !rst_int_n_o |-> !rst_ind_n_o);

  // R5
  auto_on_chk: assert property (@(posedge ref_clk) disable iff (!chip_en_i)
    (rst_int_n_o && $past(rst_int_n_o)) |-> (&oe_auto_o));

  // R6
  sync_load_chk: assert property (@(posedge ref_clk) disable iff (!chip_en_i)
    (rst_int_n_o && $past(rst_int_n_o) && $past(cfg_wr_i)) |->
    (oe_sync_o == {{2{$past(cfg_sync_oe_i[1])}}, {2{$past(cfg_sync_oe_i[0])}}}));

  // R7
  sync_hold_chk: assert property (@(posedge ref_clk) disable iff (!chip_en_i)
    (rst_int_n_o && $past(rst_int_n_o) && !$past(cfg_wr_i)) |-> $stable(oe_sync_o));
endmodule

bind por_oe_seq por_oe_seq_chk #(.AUTO_PINS(AUTO_PINS)) u_chk (
  .ref_clk       (ref_clk),
  .chip_en_i     (chip_en_i),
  .supply_ok_i   (supply_ok_i),
  .cfg_wr_i      (cfg_wr_i),
  .cfg_sync_oe_i (cfg_sync_oe_i),
  .rst_int_n_o   (rst_int_n_o),
  .rst_ind_n_o   (rst_ind_n_o),
  .oe_auto_o     (oe_auto_o),
  .oe_sync_o     (oe_sync_o)
);

// File: tb/por_oe_seq_bench.sv
`timescale 1ns/100ps
module por_oe_seq_bench;
  localparam int AUTO_PINS = 7;

  logic       pix_clk, ref_clk, pix_run;
  logic       chip_en, supply_ok, cfg_wr;
  logic [1:0] cfg_bits;
  logic       rst_int_n, rst_ind_n;
  logic [AUTO_PINS-1:0] oe_auto;
  logic [3:0] oe_sync;

  int n_chk = 0;
  int n_fail = 0;

  por_oe_seq #(.AUTO_PINS(AUTO_PINS)) u_por_oe_seq (
    .pix_clk       (pix_clk),
    .ref_clk       (ref_clk),
    .chip_en_i     (chip_en),
    .supply_ok_i   (supply_ok),
    .cfg_wr_i      (cfg_wr),
    .cfg_sync_oe_i (cfg_bits),
    .rst_int_n_o   (rst_int_n),
    .rst_ind_n_o   (rst_ind_n),
    .oe_auto_o     (oe_auto),
    .oe_sync_o     (oe_sync)
  );

  // 200 MHz reference clock: rising edges at 2.5 + 5k ns
  initial begin
    ref_clk = 1'b0;
    forever #2.5 ref_clk = ~ref_clk;
  end

  // Pixel clock, period 36 ns, rising edges at 7 + 36k ns, stoppable
  initial begin
    pix_clk = 1'b0;
    #7;
    forever begin
      if (pix_run) pix_clk = 1'b1;
      #18;
      pix_clk = 1'b0;
      #18;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic ref_wait(input int n);
    for (int i = 0; i < n; i++) @(posedge ref_clk);
    #1;
  endtask

  // Pixel edges from now until the indicator is high
  task automatic count_ind(output int n);
    n = 0;
    while (rst_ind_n !== 1'b1 && n < 400) begin
      @(posedge pix_clk);
      #1;
      n++;
    end
  endtask

  typedef struct packed {
    logic       en;
    logic       sup;
    logic       run;
    logic       wr;
    logic [1:0] bits;
    logic [7:0] wait_cyc;
    logic       e_rst;
    logic       e_auto;
    logic [3:0] e_sync;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 1'b1, 1'b1, 2'b01, 8'd4,  1'b1, 1'b1, 4'b0011}, // R6 ref pins
    '{1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 8'd4,  1'b1, 1'b1, 4'b1111}, // R6 both
    '{1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 8'd6,  1'b1, 1'b1, 4'b1111}, // R7 hold
    '{1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 8'd4,  1'b0, 1'b0, 4'b0000}, // R1
    '{1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 8'd10, 1'b1, 1'b1, 4'b0000}, // R7 cleared
    '{1'b1, 1'b1, 1'b1, 1'b1, 2'b10, 8'd4,  1'b1, 1'b1, 4'b1100}, // R6 sync pins
    '{1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 8'd4,  1'b0, 1'b0, 4'b0000}, // R2
    '{1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 8'd10, 1'b1, 1'b1, 4'b0000}, // R7 cleared
    '{1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 8'd4,  1'b1, 1'b1, 4'b1111}, // R6
    '{1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 8'd40, 1'b1, 1'b1, 4'b1111}, // R3 not yet
    '{1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 8'd60, 1'b0, 1'b0, 4'b0000}, // R3 lost
    '{1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 8'd30, 1'b1, 1'b1, 4'b0000}, // R3 recover
    '{1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 8'd4,  1'b0, 1'b0, 4'b0000}, // R7 write in reset
    '{1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 8'd10, 1'b1, 1'b1, 4'b0000}  // R7 ignored
  };

  initial begin
    #900us;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    chip_en = 1'b0; supply_ok = 1'b1; pix_run = 1'b1;
    cfg_wr = 1'b0; cfg_bits = 2'b00;
    #20;
    // R1 reset state
    check("R1 rst_int", 32'(rst_int_n), 32'd0);
    check("R8 ind", 32'(rst_ind_n), 32'd0);
    check("R1 oe_auto", 32'(oe_auto), 32'd0);
    check("R1 oe_sync", 32'(oe_sync), 32'd0);

    // R4 release on the 4th reference edge after chip-enable rises
    @(posedge ref_clk); #1;
    chip_en = 1'b1;
    ref_wait(3);
    check("R4 rst after 3 edges", 32'(rst_int_n), 32'd0);
    @(posedge ref_clk); #0.5;
    check("R4 rst after 4 edges", 32'(rst_int_n), 32'd1);
    check("R5 auto lags one cycle", 32'(oe_auto), 32'd0);
    ref_wait(1);
    check("R5 auto on", 32'(oe_auto), 32'h7f);
    check("R6 sync off after reset", 32'(oe_sync), 32'd0);

    // R8 indicator length from this release
    chip_en = 1'b0; #1;
    check("R9 ind low on new cause", 32'(rst_ind_n), 32'd0);
    ref_wait(2);
    chip_en = 1'b1;
    @(posedge rst_int_n);
    count_ind(n);
    check("R8 indicator edges", 32'(n), 32'd130);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      @(posedge ref_clk); #1;
      chip_en = VECS[v].en; supply_ok = VECS[v].sup; pix_run = VECS[v].run;
      cfg_wr = VECS[v].wr; cfg_bits = VECS[v].bits;
      ref_wait(int'(VECS[v].wait_cyc));
      check($sformatf("R1-2-3 vec%0d rst", v), 32'(rst_int_n), 32'(VECS[v].e_rst));
      check($sformatf("R5 vec%0d auto", v), 32'(oe_auto), VECS[v].e_auto ? 32'h7f : 32'd0);
      check($sformatf("R6/R7 vec%0d sync", v), 32'(oe_sync), 32'(VECS[v].e_sync));
    end
    cfg_wr = 1'b0;

    // R9 restart in the middle of the indicator window
    chip_en = 1'b0; ref_wait(3);
    chip_en = 1'b1;
    @(posedge rst_int_n);
    for (int i = 0; i < 50; i++) @(posedge pix_clk);
    #1;
    check("R9 ind still low mid-window", 32'(rst_ind_n), 32'd0);
    supply_ok = 1'b0; #1;
    check("R2 rst on supply drop", 32'(rst_int_n), 32'd0);
    check("R9 ind low after cause", 32'(rst_ind_n), 32'd0);
    ref_wait(3);
    supply_ok = 1'b1;
    @(posedge rst_int_n);
    count_ind(n);
    check("R9 full restart count", 32'(n), 32'd130);

    // R3 indicator also follows a lost-clock reset
    pix_run = 1'b0; ref_wait(100);
    check("R3 lost clock rst", 32'(rst_int_n), 32'd0);
    check("R8 ind low in lost clock", 32'(rst_ind_n), 32'd0);
    pix_run = 1'b1; ref_wait(30);
    check("R3 recovered", 32'(rst_int_n), 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule